// File: doc/BRIEF.md
# Cascadable Synchronous Up Counter

This block is an 8-bit synchronous binary up counter. It is made of two identical 4-bit stages joined by a carry chain. Each stage works in toggle form. A bit flips on a clock edge when the stage's incoming carry, the shared count enable and every lower bit of that stage are all high. Otherwise the bit keeps its value. The lower stage's outgoing carry is the upper stage's incoming carry.

Clock, count enable and the synchronous clear are common to both stages. The lower stage's incoming carry comes from an input. The upper stage's outgoing carry leaves the block as the overall carry. A designer can therefore build a wider counter by chaining several of these blocks, with no extra logic between them.

The outgoing carry is purely combinational. It depends only on the stored count, the incoming carry and the enable, so the clear input does not block it.

Top module: `casc_up_counter`

## Requirements
- R1: On a rising clock edge with `clear` low and both `carry_in` and `count_en` high, `count` (bit 0 least significant) becomes its previous value plus one.
- R2: The upper nibble `count[7:4]` changes only on an enabled edge where the lower nibble `count[3:0]` was 15. On that edge it goes up by one and the lower nibble wraps to 0.
- R3: On a rising edge with `clear` high, `count` becomes 0, whatever `carry_in` and `count_en` are.
- R4: On a rising edge with `clear` low and either `carry_in` or `count_en` low, `count` keeps its value.
- R5: `carry_out` is high in the same cycle, with no register delay, exactly when `count` is 255 and both `carry_in` and `count_en` are high.
- R6: `clear` does not gate `carry_out`. With `count` at 255 and both `carry_in` and `count_en` high, `carry_out` is high even while `clear` is high.
- R7: An enabled edge with `count` at 255 and `clear` low wraps `count` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by both stages |
| clear | input | 1 | Synchronous active-high clear to zero |
| carry_in | input | 1 | Active-high incoming carry of the lower stage |
| count_en | input | 1 | Active-high count enable shared by both stages |
| count | output | 8 | Registered count, bit 0 least significant |
| carry_out | output | 1 | Combinational outgoing carry of the upper stage |

## Verification
The hardest case to reach is `clear` asserted while the count sits at 255 with counting enabled. The count only gets there after 255 enabled edges. At that point the combinational carry must stay high even though the next edge will clear the count. The stimulus counts up step by step to all ones twice. The first time it lets the count wrap. The second time it raises `clear` in the all-ones cycle and checks the carry before the edge and the zero after it. Long random runs of enable, incoming carry and clear are then compared every cycle against a model in the bench.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;

    localparam int STAGE_BITS_DEF = 4;
    localparam int STAGE_COUNT_DEF = 2;

    // Controls shared by every stage of the chain
    typedef struct packed {
        logic run;   // count enable
        logic clr;   // synchronous clear
    } stage_ctl_t;

endpackage

// File: rtl/casc_stage.sv
module casc_stage
    import casc_cnt_pkg::*;
#(
    parameter int W = STAGE_BITS_DEF
) (
    input  logic         clk,
    input  stage_ctl_t   ctl,
    input  logic         cin,
    output logic [W-1:0] q,
    output logic         cout
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_state_t;

    stage_state_t st_d, st_q;
    logic [W-1:0] flip;

    // Toggle term of bit i: incoming carry, enable and all lower bits high
    generate
        for (genvar i = 0; i < W; i++) begin : g_flip
            if (i == 0) begin : g_lsb
                assign flip[i] = cin & ctl.run;
            end else begin : g_upper
                assign flip[i] = flip[i-1] & st_q.cnt[i-1];
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (ctl.clr) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt ^ flip;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q    = st_q.cnt;
    // Carry is independent of the clear
    assign cout = flip[W-1] & st_q.cnt[W-1];

endmodule

// File: rtl/casc_up_counter.sv
module casc_up_counter
    import casc_cnt_pkg::*;
#(
    parameter int STAGE_BITS = STAGE_BITS_DEF,
    parameter int STAGES     = STAGE_COUNT_DEF,
    localparam int TOTAL_BITS = STAGE_BITS * STAGES
) (
    input  logic                  clk,
    input  logic                  clear,
    input  logic                  carry_in,
    input  logic                  count_en,
    output logic [TOTAL_BITS-1:0] count,
    output logic                  carry_out
);

    stage_ctl_t        ctl;
    logic [STAGES:0]   chain;

    assign ctl.run  = count_en;
    assign ctl.clr  = clear;
    assign chain[0] = carry_in;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            casc_stage #(
                .W (STAGE_BITS)
            ) i_stage (
                .clk  (clk),
                .ctl  (ctl),
                .cin  (chain[s]),
                .q    (count[s*STAGE_BITS +: STAGE_BITS]),
                .cout (chain[s+1])
            );
        end
    endgenerate

    assign carry_out = chain[STAGES];

endmodule

// File: rtl/casc_up_counter_chk.sv
module casc_up_counter_chk #(
    parameter int W = 8,
    parameter int SW = 4
) (
    input logic         clk,
    input logic         clear,
    input logic         carry_in,
    input logic         count_en,
    input logic [W-1:0] count,
    input logic         carry_out
);

    logic go;
    assign go = carry_in && count_en;

    p_step_r1: assert property (@(posedge clk) disable iff (clear)
        go |=> count == W'($past(count) + 1'b1));

    p_upper_hold_r2: assert property (@(posedge clk) disable iff (clear)
        (go && count[SW-1:0] != {SW{1'b1}}) |=> $stable(count[W-1:SW]));

    p_clear_r3: assert property (@(posedge clk)
        clear |=> count == '0);

    p_hold_r4: assert property (@(posedge clk) disable iff (clear)
        !go |=> $stable(count));

    p_carry_r5: assert property (@(posedge clk) disable iff (clear)
        carry_out == (go && count == {W{1'b1}}));

    p_carry_in_clear_r6: assert property (@(posedge clk)
        (clear && go && count == {W{1'b1}}) |-> carry_out);

    p_wrap_r7: assert property (@(posedge clk) disable iff (clear)
        (go && count == {W{1'b1}}) |=> count == '0);

endmodule

bind casc_up_counter casc_up_counter_chk #(
    .W  (TOTAL_BITS),
    .SW (STAGE_BITS)
) i_chk (
    .clk       (clk),
    .clear     (clear),
    .carry_in  (carry_in),
    .count_en  (count_en),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/test_casc_up_counter.sv
module test_casc_up_counter;

    logic       clk = 1'b0;
    logic       clear = 1'b1;
    logic       carry_in = 1'b0;
    logic       count_en = 1'b0;
    logic [7:0] count;
    logic       carry_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = 8'd0;

    always #4 clk = ~clk;

    casc_up_counter i_casc_up_counter (
        .clk       (clk),
        .clear     (clear),
        .carry_in  (carry_in),
        .count_en  (count_en),
        .count     (count),
        .carry_out (carry_out)
    );

    // {clear, carry_in, count_en, expected count after the edge}
    localparam logic [10:0] VEC [0:9] = '{
        {3'b111, 8'd0},   // R3 clear beats counting
        {3'b011, 8'd1},   // R1
        {3'b011, 8'd2},   // R1
        {3'b001, 8'd2},   // R4 carry_in low
        {3'b010, 8'd2},   // R4 enable low
        {3'b000, 8'd2},   // R4 both low
        {3'b011, 8'd3},   // R1
        {3'b100, 8'd0},   // R3
        {3'b011, 8'd1},   // R1
        {3'b011, 8'd2}    // R1
    };

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, sample 2 ns later
    task automatic step(input logic r, input logic c, input logic e);
        @(negedge clk);
        clear = r; carry_in = c; count_en = e;
        @(posedge clk);
        #2;
        if (r) model = 8'd0;
        else if (c && e) model = model + 8'd1;
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        step(1'b1, 1'b0, 1'b0);
        check("R3 reset state", {1'b0, count}, 9'd0);
        check("R5 carry low at zero", {8'd0, carry_out}, 9'd0);

        for (int i = 0; i < 10; i++) begin
            step(VEC[i][10], VEC[i][9], VEC[i][8]);
            check("R1/R3/R4 vector", {1'b0, count}, {1'b0, VEC[i][7:0]});
        end

        // R2: lower nibble to 15, upper must move only then
        step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 15; i++) step(1'b0, 1'b1, 1'b1);
        check("R2 lower nibble full", {1'b0, count}, 9'd15);
        check("R2 upper untouched", {5'd0, count[7:4]}, 9'd0);
        step(1'b0, 1'b1, 1'b1);
        check("R2 upper advances", {1'b0, count}, 9'd16);

        // R5 / R7: up to 255
        for (int i = 0; i < 239; i++) step(1'b0, 1'b1, 1'b1);
        check("R1 reached 255", {1'b0, count}, 9'd255);
        #1;
        check("R5 carry high at 255", {8'd0, carry_out}, 9'd1);
        @(negedge clk); carry_in = 1'b0; #1;
        check("R5 carry needs carry_in", {8'd0, carry_out}, 9'd0);
        carry_in = 1'b1; count_en = 1'b0; #1;
        check("R5 carry needs enable", {8'd0, carry_out}, 9'd0);
        step(1'b0, 1'b1, 1'b1);
        check("R7 wrap to zero", {1'b0, count}, 9'd0);

        // R6: clear while all ones and counting
        for (int i = 0; i < 255; i++) step(1'b0, 1'b1, 1'b1);
        @(negedge clk); clear = 1'b1; #1;
        check("R6 carry high during clear", {8'd0, carry_out}, 9'd1);
        @(posedge clk); #2;
        model = 8'd0;
        check("R6 clear wins at 255", {1'b0, count}, 9'd0);

        // Random run against the model
        for (int i = 0; i < 3000; i++) begin
            logic r, c, e;
            r = ($urandom_range(0, 15) == 0);
            c = ($urandom_range(0, 7) != 0);
            e = ($urandom_range(0, 3) != 0);
            @(negedge clk);
            clear = r; carry_in = c; count_en = e;
            #1;
            check("R5/R6 random carry", {8'd0, carry_out},
                  {8'd0, (model == 8'hFF) && c && e});
            @(posedge clk); #2;
            if (r) model = 8'd0;
            else if (c && e) model = model + 8'd1;
            check("R1/R3/R4/R7 random count", {1'b0, count}, {1'b0, model});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule